// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block runs on a fast input clock and produces a divided clock level for downstream sampling logic. The division ratio can be any integer from 1 to 8. An external sync pulse returns the divider to a fixed starting phase. Several copies of the block that share one input clock and one sync line therefore produce divided outputs that line up edge for edge.

A single control register sets the ratio, the stabilizer request and the sync handling. It is written through a plain strobe with address and data. Sync handling can be off, active on every sync pulse, or one-shot: a register write arms the block, and the first accepted pulse after that write disarms it. The block also drives the enable for the downstream duty-cycle stabilizer. Any ratio other than 1 forces that enable on.

Top module: `clkdiv_top`

## Requirements
- R1: The control register sits at address 0x100. Its bits [6:4] hold code c, and the divided period is c+1 input cycles (c = 0 gives ratio 1, c = 7 gives ratio 8).
- R2: Within each period of ratio N, `div_clk_o` is high for the first ceil(N/2) input cycles and low for the remaining floor(N/2). With ratio 1 it stays high.
- R3: `dcs_en_o` equals control bit 0 OR (ratio code not zero).
- R4: `sync_i` passes through a two-flop synchronizer, and the rising edge is the sync event. For an accepted event, phase 0 of a new period, with the register's current ratio, begins on the second clock edge after the edge that first samples `sync_i` high. This latency is the same for every ratio.
- R5: When control bit 1 (sync enable) is 0, sync pulses have no effect on `div_clk_o`.
- R6: A sync pulse held high for many cycles produces exactly one reset of the phase.
- R7: With bit 1 set and bit 2 clear, every sync event is accepted. With bits 1 and 2 set, any write to 0x100 arms the block, and only the first sync event after the write is accepted, which disarms it. `armed_o` reads 1 while one-shot mode is selected and the block is armed.
- R8: A ratio change written without sync takes effect at the next period boundary. The running period completes with the old ratio, so no short pulse appears.
- R9: After reset the ratio is 1, all control bits are 0, `div_clk_o` is high, and `dcs_en_o` and `armed_o` are low. Writes to other addresses, and to bits 3 and 7 of 0x100, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (12) | Register write address |
| wr_data_i | input | DATA_W (8) | Register write data |
| sync_i | input | 1 | Sync request, asynchronous to clk_i |
| div_clk_o | output | 1 | Divided clock level |
| dcs_en_o | output | 1 | Duty-cycle stabilizer enable |
| armed_o | output | 1 | One-shot sync is armed |

## Verification
The assertions assume that `sync_i` stays low long enough between pulses for the synchronizer to show a low level, so that each edge counts as a separate event. They also assume that register writes land on the clock like any synchronous input. The stimulus drives every input on the falling edge and holds each one for at least one full cycle. Sync pulses are either one cycle wide or deliberately held for many cycles, and each is followed by low time before the next pulse. In the one-shot and ratio-change sequences, writes fall at known phases, so the expected waveform follows from arithmetic on the cycle count alone.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    code_t code;
    logic  oneshot;
    logic  sync_en;
    logic  dcs_req;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '0;
  localparam logic [CODE_W:0] TWO = 2;

  // cycles of high level for ratio code c (ratio c+1)
  function automatic logic [CODE_W:0] high_len(code_t c);
    return ({1'b0, c} + TWO) >> 1;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h100,
  parameter int unsigned DCS_BIT     = 0,
  parameter int unsigned SYNC_EN_BIT = 1,
  parameter int unsigned ONESHOT_BIT = 2,
  parameter int unsigned CODE_LSB    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sync_acc_i,
  output ctrl_t             ctrl_o,
  output logic              armed_o,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] ONE = 1;
  localparam logic [DATA_W-1:0] CODE_MASK = {{(DATA_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << CODE_LSB;
  localparam logic [DATA_W-1:0] USED_MASK = CODE_MASK | (ONE << DCS_BIT)
                                          | (ONE << SYNC_EN_BIT) | (ONE << ONESHOT_BIT);

  ctrl_t ctrl_q;
  logic  armed_q;
  logic  unused_bits;

  assign hit_o       = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign unused_bits = |(wr_data_i & ~USED_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      armed_q <= 1'b0;
    end else if (hit_o) begin
      ctrl_q.code    <= wr_data_i[CODE_LSB +: CODE_W];
      ctrl_q.oneshot <= wr_data_i[ONESHOT_BIT];
      ctrl_q.sync_en <= wr_data_i[SYNC_EN_BIT];
      ctrl_q.dcs_req <= wr_data_i[DCS_BIT];
      armed_q        <= 1'b1;
    end else if (sync_acc_i && ctrl_q.oneshot) begin
      armed_q <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign armed_o = armed_q & ctrl_q.oneshot;
endmodule

// File: rtl/clkdiv_sync_edge.sv
module clkdiv_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], sync_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign edge_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t code_i,
  input  logic  resync_i,
  output logic  div_o,
  output code_t cnt_o,
  output code_t code_act_o,
  output logic  wrap_o
);
  code_t cnt_q, act_q, cnt_nx;
  logic  div_q;

  assign wrap_o = (cnt_q == act_q);
  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      div_q <= 1'b1;
    end else if (resync_i || wrap_o) begin
      // new period: ratio is latched only here
      cnt_q <= '0;
      act_q <= code_i;
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      div_q <= ({1'b0, cnt_nx} < high_len(act_q));
    end
  end

  assign div_o      = div_q;
  assign cnt_o      = cnt_q;
  assign code_act_o = act_q;
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sync_i,
  output logic              div_clk_o,
  output logic              dcs_en_o,
  output logic              armed_o
);
  ctrl_t ctrl;
  logic  ctrl_hit, sync_edge, sync_acc, wrap;
  code_t cnt, code_act;

  clkdiv_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sync_acc_i(sync_acc),
    .ctrl_o    (ctrl),
    .armed_o   (armed_o),
    .hit_o     (ctrl_hit)
  );

  clkdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_i),
    .edge_o(sync_edge)
  );

  assign sync_acc = sync_edge && ctrl.sync_en && (!ctrl.oneshot || armed_o);

  clkdiv_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (ctrl.code),
    .resync_i  (sync_acc),
    .div_o     (div_clk_o),
    .cnt_o     (cnt),
    .code_act_o(code_act),
    .wrap_o    (wrap)
  );

  assign dcs_en_o = ctrl.dcs_req || (ctrl.code != '0);
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
  import clkdiv_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  div_clk_o,
  input logic  dcs_en_o,
  input logic  armed_o,
  input code_t code_reg,
  input logic  oneshot_reg,
  input logic  sync_en_reg,
  input code_t code_act,
  input code_t cnt,
  input logic  wrap,
  input logic  sync_edge,
  input logic  sync_acc,
  input logic  ctrl_hit
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= code_act); // R1

  AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> div_clk_o); // R2

  AST_DCS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_reg != '0) |-> dcs_en_o); // R3

  AST_SYNC_PHASE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_acc |=> (cnt == '0) && div_clk_o && (code_act == $past(code_reg))); // R4

  AST_SYNC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_edge && !sync_en_reg && !wrap) |=> (cnt == $past(cnt) + 1'b1)); // R5

  AST_SYNC_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_edge |=> !sync_edge); // R6

  AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_acc && !ctrl_hit) |=> !armed_o); // R7

  AST_WRITE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |=> (armed_o == oneshot_reg)); // R7

  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap && !sync_acc) |=> $stable(code_act)); // R8
endmodule

bind clkdiv_top clkdiv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_clk_o  (div_clk_o),
  .dcs_en_o   (dcs_en_o),
  .armed_o    (armed_o),
  .code_reg   (ctrl.code),
  .oneshot_reg(ctrl.oneshot),
  .sync_en_reg(ctrl.sync_en),
  .code_act   (code_act),
  .cnt        (cnt),
  .wrap       (wrap),
  .sync_edge  (sync_edge),
  .sync_acc   (sync_acc),
  .ctrl_hit   (ctrl_hit)
);

// File: tb/sim_clkdiv_top.sv
module sim_clkdiv_top;
  localparam logic [11:0] CTRL = 12'h100;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sync = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  data = '0;
  logic       div_clk, dcs_en, armed;

  int n_chk = 0, n_fail = 0, t_ph = 0, n_cur = 1;

  always #4 clk = ~clk;

  clkdiv_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_data_i(data), .sync_i(sync), .div_clk_o(div_clk),
    .dcs_en_o(dcs_en), .armed_o(armed)
  );

  function automatic logic exp_div(int t, int n);
    return ((t % n) < (n + 1) / 2);
  endfunction

  // bits: 0 stabilizer, 1 sync enable, 2 one-shot, [6:4] ratio-1
  function automatic logic [7:0] cfg(int n, bit dcs, bit en, bit os);
    return {1'b0, 3'(n - 1), 1'b0, os, en, dcs};
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (phase %0d, ratio %0d)", req, act, exp, t_ph, n_cur);
    end
  endtask

  task automatic cyc(string req);
    @(negedge clk);
    t_ph++;
    check(req, div_clk, exp_div(t_ph, n_cur));
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_sync(int n);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    t_ph = 0; n_cur = n;
    check("R4", div_clk, 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 div", div_clk, 1'b1);
    check("R9 dcs", dcs_en, 1'b0);
    check("R9 armed", armed, 1'b0);

    // R9: foreign address and unused bits ignored
    wr(12'h101, 8'hFF);
    check("R9 addr dcs", dcs_en, 1'b0);
    check("R9 addr armed", armed, 1'b0);
    wr(CTRL, 8'h88);
    check("R9 unused dcs", dcs_en, 1'b0);
    check("R9 unused armed", armed, 1'b0);
    n_cur = 1; t_ph = 0;
    repeat (4) cyc("R9 ratio");

    // R3: stabilizer enable over all codes
    for (int c = 1; c <= 8; c++) begin
      for (int d = 0; d < 2; d++) begin
        wr(CTRL, cfg(c, d[0], 1'b0, 1'b0));
        check("R3", dcs_en, (d != 0) || (c != 1));
      end
    end

    // R1 R2 R4: full ratio sweep
    for (int n = 1; n <= 8; n++) begin
      wr(CTRL, cfg(n, 1'b0, 1'b1, 1'b0));
      do_sync(n);
      repeat (3 * n) cyc("R1 R2");
    end

    // R5: sync disabled
    wr(CTRL, cfg(4, 1'b0, 1'b1, 1'b0));
    do_sync(4);
    repeat (2) cyc("R5");
    wr_en = 1'b1; addr = CTRL; data = cfg(4, 1'b0, 1'b0, 1'b0);
    cyc("R5");
    wr_en = 1'b0;
    sync = 1'b1;
    cyc("R5");
    sync = 1'b0;
    repeat (12) cyc("R5");

    // R6: long pulse gives one reset
    wr_en = 1'b1; data = cfg(4, 1'b0, 1'b1, 1'b0);
    cyc("R6");
    wr_en = 1'b0;
    sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    t_ph = 0; n_cur = 4;
    check("R4 long", div_clk, 1'b1);
    repeat (16) cyc("R6");
    sync = 1'b0;
    repeat (6) cyc("R6");

    // R8: ratio change waits for boundary
    wr(CTRL, cfg(3, 1'b0, 1'b1, 1'b0));
    do_sync(3);
    cyc("R8");
    wr_en = 1'b1; data = cfg(5, 1'b0, 1'b1, 1'b0);
    cyc("R8");
    wr_en = 1'b0;
    t_ph = -1; n_cur = 5;
    repeat (12) cyc("R8");

    // R7: every-sync mode realigns mid-period
    wr(CTRL, cfg(6, 1'b0, 1'b1, 1'b0));
    do_sync(6);
    repeat (2) cyc("R7");
    do_sync(6);
    repeat (12) cyc("R7");
    check("R7 armed every", armed, 1'b0);

    // R7: one-shot mode
    wr(CTRL, cfg(3, 1'b0, 1'b1, 1'b1));
    check("R7 armed", armed, 1'b1);
    do_sync(3);
    check("R7 disarm", armed, 1'b0);
    repeat (2) cyc("R7");
    sync = 1'b1;
    cyc("R7");
    sync = 1'b0;
    repeat (9) cyc("R7 ignored");
    wr_en = 1'b1; data = cfg(3, 1'b0, 1'b1, 1'b1);
    cyc("R7");
    wr_en = 1'b0;
    check("R7 rearm", armed, 1'b1);
    do_sync(3);
    check("R7 disarm2", armed, 1'b0);
    repeat (6) cyc("R7");

    finish_run();
  end
endmodule